// File: doc/BRIEF.md
# DMA Completion Retire Tracker

This block follows the transmit requests that software has placed on a circular descriptor ring and retires them in order as the hardware consumer pointer moves forward. Every request sits in a small FIFO together with a running index (initially its first descriptor), an end index (one past its last descriptor), a tag and a flag that asks for a release pulse on each of its descriptors. While the engine reports that it is running, the tracker walks its own software head toward the hardware head one descriptor per clock. It counts every descriptor it passes, including the header descriptors that belong to no tracked request, and signals completion of the oldest request once the head passes that request's end.

An abort command stops retirement and drains the FIFO, so every pending request completes with an aborted status. Where requested, the descriptors not yet released are released first. The removed count is then brought level with the added count without ever going backwards, and the software head returns to 0. A request offered while the engine is stopped is queued as an empty request and drained at once with aborted status, together with anything older, and the counters are left alone.

Top module: `dma_retire_tracker`

## Requirements
- R1: While `eng_running` is high and no drain is in progress, `sw_head` moves one step per clock toward `hw_head`, going from 11 back to 0 (the ring holds 12 descriptors). The new value shows one clock after the edge that samples the step.
- R2: `removed_cnt` grows by exactly one for each descriptor the head passes, whether or not that descriptor belongs to a tracked request.
- R3: The oldest request completes with `done_aborted` = 0 in the same cycle that `sw_head` first equals its end index. The next request then becomes the oldest. There is at most one completion per clock, and tags appear in the order they were queued.
- R4: A `rel_valid` pulse with `rel_idx` equal to the descriptor passed is given only when the oldest request has its release flag set and its running index equals that descriptor. Descriptors before a request's start produce no pulse.
- R5: After `abort_req`, every queued request completes in FIFO order with `done_aborted` = 1. Before its completion, a request with the release flag releases each index from its running index up to its end, one per clock, with wrap.
- R6: At the end of an abort drain, `removed_cnt` takes the added count unless that value is lower, in which case it is kept. `sw_head` returns to 0.
- R7: A request accepted while `eng_running` is low is stored with start and end 0 and no release. Its descriptor count is not added. It and all older requests complete aborted without changing `removed_cnt`.
- R8: In each cycle in which the head advanced, `space_valid` pulses. `space_free` always equals 11 minus (added minus removed), taken modulo 32.
- R9: While `eng_running` is low, outside a drain, `sw_head` and `removed_cnt` hold.
- R10: `enq_ready` is low when the 4-entry request FIFO is full, during a drain, and while `abort_req` is high.
- R11: Each request accepted while running adds its `enq_ndesc` to the added count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_running | input | 1 | Engine is in its running state |
| hw_head | input | 4 | Hardware consumer index in the ring |
| abort_req | input | 1 | Start an abort drain |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Request accepted this cycle when valid |
| enq_tag | input | 4 | Request tag returned on completion |
| enq_start | input | 4 | First tracked descriptor index |
| enq_end | input | 4 | One past the last descriptor index |
| enq_ndesc | input | 4 | Descriptors the request added to the ring |
| enq_release | input | 1 | Release pulse wanted per descriptor |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | 4 | Tag of the completed request |
| done_aborted | output | 1 | 1 = aborted, 0 = OK |
| rel_valid | output | 1 | Descriptor release pulse |
| rel_idx | output | 4 | Index released |
| space_valid | output | 1 | Free-space notification |
| space_free | output | 5 | Free descriptor slots |
| sw_head | output | 4 | Software head index |
| removed_cnt | output | 32 | Descriptors removed since reset |

## Verification
The hardest situation to reach is an abort drain that finds a request partly retired, with its running index in the middle of its range and its range wrapping past the ring end. A second hard case is a drain that begins when more descriptors have been removed than added. The stimulus fills the FIFO, lets the head retire only part of the first request, and then aborts. It then moves the hardware head over descriptors that no request ever added, and aborts again. Both cases check the release order and confirm that the removed count does not move backwards.

// File: rtl/dmart_pkg.sv
package dmart_pkg;
    localparam int unsigned RING_DEPTH = 12;
    localparam int unsigned IDX_W      = $clog2(RING_DEPTH);
    localparam int unsigned TAG_W      = 4;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        tag_t tag;
        idx_t run_idx;
        idx_t end_idx;
        logic rel_en;
    } req_t;

    typedef enum logic [1:0] {
        MODE_LIVE      = 2'd0,
        MODE_DRAIN_ERR = 2'd1,
        MODE_DRAIN_ABT = 2'd2
    } mode_e;

    function automatic idx_t idx_next(input idx_t i);
        if (i == idx_t'(RING_DEPTH - 1)) return '0;
        return i + idx_t'(1);
    endfunction
endpackage

// File: rtl/dmart_req_fifo.sv
module dmart_req_fifo
    import dmart_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  req_t push_data,
    input  logic pop,
    input  logic upd,
    input  idx_t upd_run,
    output req_t head,
    output logic empty,
    output logic full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    req_t             mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= ptr_next(wr_q);
            if (pop)  rd_q <= ptr_next(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
        if (upd && !pop) mem[rd_q].run_idx <= upd_run;
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R10
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R3
    AST_FIFO_UPD_LIVE: assert property (@(posedge clk) disable iff (rst)
        upd |-> !empty); // R4
endmodule

// File: rtl/dmart_count.sv
module dmart_count
    import dmart_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  idx_t             add_n,
    input  logic             rm_step,
    input  logic             resync,
    output logic [CNT_W-1:0] removed,
    output logic [IDX_W:0]   free_cnt
);
    logic [CNT_W-1:0] added_q, removed_q, gap, free_full;

    assign gap       = added_q - removed_q;
    assign free_full = CNT_W'(RING_DEPTH - 1) - gap;
    assign free_cnt  = free_full[IDX_W:0];
    assign removed   = removed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            added_q   <= '0;
            removed_q <= '0;
        end else begin
            if (add_en) added_q <= added_q + CNT_W'(add_n);
            if (resync) begin
                if (!gap[CNT_W-1]) removed_q <= added_q;
            end else if (rm_step) begin
                removed_q <= removed_q + CNT_W'(1);
            end
        end
    end

    logic [CNT_W-1:0] rm_prev_q, rm_delta;
    always_ff @(posedge clk) begin
        if (rst) rm_prev_q <= '0;
        else     rm_prev_q <= removed_q;
    end
    assign rm_delta = removed_q - rm_prev_q;

    AST_REMOVED_MONO: assert property (@(posedge clk) disable iff (rst)
        !rm_delta[CNT_W-1]); // R6
    AST_REMOVED_UNIT: assert property (@(posedge clk) disable iff (rst)
        !$past(resync) |-> (rm_delta == '0 || rm_delta == CNT_W'(1))); // R2
endmodule

// File: rtl/dmart_seq.sv
module dmart_seq
    import dmart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  idx_t hw_head,
    input  logic abort,
    input  logic enq_valid,
    input  tag_t enq_tag,
    input  idx_t enq_start,
    input  idx_t enq_end,
    input  logic enq_rel,
    output logic enq_ready,
    input  req_t fifo_head,
    input  logic fifo_empty,
    input  logic fifo_full,
    output logic fifo_push,
    output req_t fifo_push_data,
    output logic fifo_pop,
    output logic fifo_upd,
    output idx_t fifo_upd_run,
    output logic cnt_add_en,
    output logic cnt_rm_step,
    output logic cnt_resync,
    output idx_t sw_head,
    output logic cmpl_valid,
    output tag_t cmpl_tag,
    output logic cmpl_aborted,
    output logic rel_valid,
    output idx_t rel_idx,
    output logic notify
);
    mode_e mode_q;
    idx_t  sw_head_q, nh;
    logic  live, enq_take, step, hit, done_ok;
    logic  drain_rel, drain_pop, drain_end;
    logic  cmpl_valid_q, cmpl_aborted_q, rel_valid_q, notify_q;
    tag_t  cmpl_tag_q;
    idx_t  rel_idx_q;

    always_comb begin
        live      = (mode_q == MODE_LIVE);
        enq_ready = live && !fifo_full && !abort;
        enq_take  = enq_valid && enq_ready;
        nh        = idx_next(sw_head_q);
        step      = live && running && !abort && (sw_head_q != hw_head);
        hit       = step && !fifo_empty && fifo_head.rel_en &&
                    (fifo_head.run_idx == sw_head_q);
        done_ok   = step && !fifo_empty && (fifo_head.end_idx == nh);
        drain_rel = !live && !fifo_empty && fifo_head.rel_en &&
                    (fifo_head.run_idx != fifo_head.end_idx);
        drain_pop = !live && !fifo_empty && !drain_rel;
        drain_end = !live && fifo_empty;

        fifo_push = enq_take;
        if (running) fifo_push_data = '{tag: enq_tag, run_idx: enq_start,
                                        end_idx: enq_end, rel_en: enq_rel};
        else         fifo_push_data = '{tag: enq_tag, run_idx: '0,
                                        end_idx: '0, rel_en: 1'b0};
        fifo_pop     = done_ok || drain_pop;
        fifo_upd     = hit || drain_rel;
        fifo_upd_run = idx_next(fifo_head.run_idx);
        cnt_add_en   = enq_take && running;
        cnt_rm_step  = step;
        cnt_resync   = drain_end && (mode_q == MODE_DRAIN_ABT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q         <= MODE_LIVE;
            sw_head_q      <= '0;
            cmpl_valid_q   <= 1'b0;
            cmpl_aborted_q <= 1'b0;
            cmpl_tag_q     <= '0;
            rel_valid_q    <= 1'b0;
            rel_idx_q      <= '0;
            notify_q       <= 1'b0;
        end else begin
            if (live) begin
                if (abort)                     mode_q <= MODE_DRAIN_ABT;
                else if (enq_take && !running) mode_q <= MODE_DRAIN_ERR;
            end else begin
                if (abort)           mode_q <= MODE_DRAIN_ABT;
                else if (fifo_empty) mode_q <= MODE_LIVE;
            end
            if (step)            sw_head_q <= nh;
            else if (cnt_resync) sw_head_q <= '0;
            cmpl_valid_q   <= done_ok || drain_pop;
            cmpl_aborted_q <= drain_pop;
            cmpl_tag_q     <= fifo_head.tag;
            rel_valid_q    <= hit || drain_rel;
            rel_idx_q      <= fifo_head.run_idx;
            notify_q       <= step;
        end
    end

    assign sw_head      = sw_head_q;
    assign cmpl_valid   = cmpl_valid_q;
    assign cmpl_tag     = cmpl_tag_q;
    assign cmpl_aborted = cmpl_aborted_q;
    assign rel_valid    = rel_valid_q;
    assign rel_idx      = rel_idx_q;
    assign notify       = notify_q;

    AST_HEAD_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (sw_head_q != $past(sw_head_q)) |->
        (sw_head_q == idx_next($past(sw_head_q)) || sw_head_q == '0)); // R1
    AST_NOTIFY_ADV: assert property (@(posedge clk) disable iff (rst)
        notify_q |-> (sw_head_q == idx_next($past(sw_head_q)))); // R8
    AST_ABORT_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid_q && cmpl_aborted_q) |-> $past(mode_q != MODE_LIVE)); // R5
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        $past(!running && mode_q == MODE_LIVE) |-> $stable(sw_head_q)); // R9
    AST_OK_NOT_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid_q && !cmpl_aborted_q) |-> $past(running)); // R3
endmodule

// File: rtl/dma_retire_tracker.sv
module dma_retire_tracker
    import dmart_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CNT_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    eng_running,
    input  logic [IDX_W-1:0]        hw_head,
    input  logic                    abort_req,
    input  logic                    enq_valid,
    output logic                    enq_ready,
    input  logic [TAG_W-1:0]        enq_tag,
    input  logic [IDX_W-1:0]        enq_start,
    input  logic [IDX_W-1:0]        enq_end,
    input  logic [IDX_W-1:0]        enq_ndesc,
    input  logic                    enq_release,
    output logic                    done_valid,
    output logic [TAG_W-1:0]        done_tag,
    output logic                    done_aborted,
    output logic                    rel_valid,
    output logic [IDX_W-1:0]        rel_idx,
    output logic                    space_valid,
    output logic [IDX_W:0]          space_free,
    output logic [IDX_W-1:0]        sw_head,
    output logic [CNT_W-1:0]        removed_cnt
);
    req_t fifo_head, fifo_push_data;
    logic fifo_empty, fifo_full, fifo_push, fifo_pop, fifo_upd;
    idx_t fifo_upd_run;
    logic cnt_add_en, cnt_rm_step, cnt_resync;

    dmart_req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(fifo_push), .push_data(fifo_push_data),
        .pop(fifo_pop), .upd(fifo_upd), .upd_run(fifo_upd_run),
        .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
    );

    dmart_seq u_seq (
        .clk(clk), .rst(rst), .running(eng_running), .hw_head(hw_head),
        .abort(abort_req), .enq_valid(enq_valid), .enq_tag(enq_tag),
        .enq_start(enq_start), .enq_end(enq_end), .enq_rel(enq_release),
        .enq_ready(enq_ready), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_push(fifo_push),
        .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop),
        .fifo_upd(fifo_upd), .fifo_upd_run(fifo_upd_run),
        .cnt_add_en(cnt_add_en), .cnt_rm_step(cnt_rm_step),
        .cnt_resync(cnt_resync), .sw_head(sw_head),
        .cmpl_valid(done_valid), .cmpl_tag(done_tag),
        .cmpl_aborted(done_aborted), .rel_valid(rel_valid),
        .rel_idx(rel_idx), .notify(space_valid)
    );

    dmart_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .add_en(cnt_add_en), .add_n(enq_ndesc),
        .rm_step(cnt_rm_step), .resync(cnt_resync),
        .removed(removed_cnt), .free_cnt(space_free)
    );
endmodule

// File: tb/dma_retire_tracker_bench.sv
module dma_retire_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eng_running = 1'b0;
    logic [3:0]  hw_head = '0;
    logic        abort_req = 1'b0;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [3:0]  enq_tag = '0, enq_start = '0, enq_end = '0, enq_ndesc = '0;
    logic        enq_release = 1'b0;
    logic        done_valid, done_aborted, rel_valid, space_valid;
    logic [3:0]  done_tag, rel_idx, sw_head;
    logic [4:0]  space_free;
    logic [31:0] removed_cnt;

    always #10 clk = ~clk;

    dma_retire_tracker u_dma_retire_tracker (
        .clk(clk), .rst(rst), .eng_running(eng_running), .hw_head(hw_head),
        .abort_req(abort_req), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_tag(enq_tag), .enq_start(enq_start), .enq_end(enq_end),
        .enq_ndesc(enq_ndesc), .enq_release(enq_release),
        .done_valid(done_valid), .done_tag(done_tag),
        .done_aborted(done_aborted), .rel_valid(rel_valid), .rel_idx(rel_idx),
        .space_valid(space_valid), .space_free(space_free),
        .sw_head(sw_head), .removed_cnt(removed_cnt)
    );

    int total = 0;
    int bad = 0;
    int exp_added = 0;
    int notify_seen = 0;
    bit finished = 1'b0;
    logic [3:0] q_tag[$];
    logic       q_ab[$];
    logic [3:0] q_rel[$];

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic exp_done(input logic [3:0] tag, input logic ab);
        q_tag.push_back(tag);
        q_ab.push_back(ab);
    endtask

    task automatic exp_rel(input logic [3:0] idx);
        q_rel.push_back(idx);
    endtask

    // driver: offers one request and waits for acceptance (R11 bookkeeping)
    task automatic push_req(input logic [3:0] tag, input logic [3:0] s,
                            input logic [3:0] e, input logic [3:0] n,
                            input logic f);
        bit taken = 1'b0;
        @(negedge clk);
        enq_valid = 1'b1; enq_tag = tag; enq_start = s; enq_end = e;
        enq_ndesc = n; enq_release = f;
        while (!taken) begin
            #1;
            if (enq_ready) begin
                @(posedge clk);
                taken = 1'b1;
                if (eng_running) exp_added += int'(n);
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations as the design produces results
    always @(negedge clk) begin
        if (!rst) begin
            if (done_valid) begin
                if (q_tag.size() == 0) begin
                    check(1'b0, "R3 unexpected completion", done_tag, -1);
                end else begin
                    automatic logic [3:0] et = q_tag.pop_front();
                    automatic logic ea = q_ab.pop_front();
                    check(done_tag == et, "R3 completion tag order", done_tag, et);
                    check(done_aborted == ea, "R5 completion status", done_aborted, ea);
                end
            end
            if (rel_valid) begin
                if (q_rel.size() == 0) begin
                    check(1'b0, "R4 unexpected release", rel_idx, -1);
                end else begin
                    automatic logic [3:0] er = q_rel.pop_front();
                    check(rel_idx == er, "R4 release index", rel_idx, er);
                end
            end
            if (space_valid) begin
                automatic logic [4:0] ef = 5'((11 - (exp_added - int'(removed_cnt))) & 31);
                notify_seen++;
                check(space_free == ef, "R8 free count on notify", space_free, ef);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sw_head == 0, "R1 reset head", sw_head, 0);
        check(removed_cnt == 0, "R2 reset removed", removed_cnt, 0);
        check(done_valid == 0, "R3 reset completion", done_valid, 0);
        check(enq_ready == 1, "R10 reset ready", enq_ready, 1);
        check(space_free == 11, "R8 reset free", space_free, 11);

        // A: two requests, first has untracked header at 0, second no release
        eng_running = 1'b1;
        push_req(4'd1, 4'd1, 4'd4, 4'd4, 1'b1);
        push_req(4'd2, 4'd5, 4'd7, 4'd3, 1'b0);
        idle(1);
        check(space_free == 4, "R11 added count", space_free, 4);
        exp_rel(4'd1); exp_rel(4'd2); exp_rel(4'd3);
        exp_done(4'd1, 1'b0); exp_done(4'd2, 1'b0);
        notify_seen = 0;
        hw_head = 4'd7;
        idle(15);
        check(sw_head == 7, "R1 head reaches hw head", sw_head, 7);
        check(removed_cnt == 7, "R2 removed incl untracked", removed_cnt, 7);
        check(notify_seen == 7, "R8 notify per advance", notify_seen, 7);

        // B: request wrapping the ring end
        push_req(4'd3, 4'd8, 4'd2, 4'd7, 1'b1);
        exp_rel(4'd8); exp_rel(4'd9); exp_rel(4'd10); exp_rel(4'd11);
        exp_rel(4'd0); exp_rel(4'd1);
        exp_done(4'd3, 1'b0);
        hw_head = 4'd2;
        idle(15);
        check(sw_head == 2, "R1 head wraps at 12", sw_head, 2);
        check(removed_cnt == 14, "R2 removed after wrap", removed_cnt, 14);

        // C: engine stopped holds retirement
        push_req(4'd4, 4'd3, 4'd5, 4'd3, 1'b1);
        eng_running = 1'b0;
        hw_head = 4'd5;
        idle(6);
        check(sw_head == 2, "R9 head holds when stopped", sw_head, 2);
        check(removed_cnt == 14, "R9 removed holds when stopped", removed_cnt, 14);
        exp_rel(4'd3); exp_rel(4'd4); exp_done(4'd4, 1'b0);
        eng_running = 1'b1;
        idle(10);
        check(removed_cnt == 17, "R2 removed after resume", removed_cnt, 17);

        // D: fill FIFO, retire part, abort mid request
        push_req(4'd5, 4'd6, 4'd9, 4'd4, 1'b1);
        push_req(4'd6, 4'd10, 4'd1, 4'd5, 1'b1);
        push_req(4'd7, 4'd2, 4'd4, 4'd3, 1'b0);
        push_req(4'd8, 4'd5, 4'd6, 4'd2, 1'b0);
        @(negedge clk);
        enq_valid = 1'b1; enq_tag = 4'd9;
        #1;
        check(enq_ready == 0, "R10 ready low when full", enq_ready, 0);
        @(negedge clk);
        enq_valid = 1'b0;
        exp_rel(4'd6);
        hw_head = 4'd7;
        idle(8);
        check(removed_cnt == 19, "R2 removed before abort", removed_cnt, 19);
        eng_running = 1'b0;
        hw_head = 4'd0;
        exp_rel(4'd7); exp_rel(4'd8); exp_done(4'd5, 1'b1);
        exp_rel(4'd10); exp_rel(4'd11); exp_rel(4'd0); exp_done(4'd6, 1'b1);
        exp_done(4'd7, 1'b1); exp_done(4'd8, 1'b1);
        pulse_abort();
        idle(15);
        check(removed_cnt == 31, "R6 removed resync to added", removed_cnt, 31);
        check(sw_head == 0, "R6 head reset after abort", sw_head, 0);

        // removed ahead of added: abort must not lower it
        eng_running = 1'b1;
        hw_head = 4'd3;
        idle(8);
        check(removed_cnt == 34, "R2 untracked descriptors counted", removed_cnt, 34);
        eng_running = 1'b0;
        hw_head = 4'd0;
        pulse_abort();
        idle(8);
        check(removed_cnt == 34, "R6 removed never decreases", removed_cnt, 34);
        check(sw_head == 0, "R6 head reset second abort", sw_head, 0);

        // E: submission while stopped drains older request too
        eng_running = 1'b1;
        push_req(4'd11, 4'd1, 4'd3, 4'd3, 1'b0);
        eng_running = 1'b0;
        exp_done(4'd11, 1'b1); exp_done(4'd12, 1'b1);
        push_req(4'd12, 4'd7, 4'd9, 4'd2, 1'b1);
        idle(10);
        check(removed_cnt == 34, "R7 no resync on stopped submit", removed_cnt, 34);
        check(sw_head == 0, "R7 head unchanged", sw_head, 0);
        check(space_free == 11, "R7 stopped submit adds nothing", space_free, 11);
        check(enq_ready == 1, "R10 ready after drain", enq_ready, 1);

        check(q_tag.size() == 0, "R3 all completions seen", q_tag.size(), 0);
        check(q_rel.size() == 0, "R4 all releases seen", q_rel.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule